// File: doc/BRIEF.md
# Buffered NOR Flash Program Sequencer

This block copies a run of 16-bit words from a local source buffer into a parallel NOR flash device, using the device's write-buffer command set. The run is cut into chunks of at most the buffer depth given with the request. For each chunk the sequencer asks the device for a free buffer, retrying until the device reports ready. It then writes the word count, streams the data words and confirms. After that it polls the device status until the operation completes, decodes any error bits, and finally reads the chunk back to compare it with the source.

A request gives a start word address, a length in bytes and the buffer depth in words. The sequencer fetches source words through an index port whose data returns in the same cycle. It reaches the flash through a simple request/acknowledge memory-master port. Every run, whether it succeeds or aborts, ends with a return-to-array write at the device base address. After that write, a one-cycle done pulse carries the result code.

Top module: `nor_bufprog_seq`

## Requirements
- R1: The first flash access of every run is a write of 0x0050 to the device base address, which is the start address ANDed with the BASE_MASK parameter.
- R2: Chunk size: a chunk has the full depth when the remaining length in words (bytes/2) is at least the depth. Otherwise the chunk has bytes/2 words, plus one when the byte count is odd, and it is the last chunk.
- R3: Each chunk opens with a write of 0x00E8 to the chunk address followed by a status read at that address. The pair repeats until status bit 7 (0x80) is set. After MAX_TRIES pairs without ready, the run aborts with result 1 (timeout).
- R4: After buffer ready, the sequencer writes (word count − 1) to the chunk address. It then writes the data words to consecutive word addresses starting at the chunk address, then writes 0x00D0 to the chunk address.
- R5: After the confirm, status at the chunk address is read until bit 7 is set. After MAX_TRIES reads without ready, the run aborts with result 1 (timeout).
- R6: A ready status is checked under mask 0x7E. Bit 4 (0x10) clear gives result 2 (device fault). Otherwise, bit 3 (0x08) gives 3 (low voltage), else bit 1 (0x02) gives 4 (protected), else 5 (program fail).
- R7: A status error ends the run at once. No further chunk is started and no 0x0050 follows the failing poll.
- R8: A clean chunk is followed by writes of 0x0050 then 0x00FF at the chunk address, then a read of every chunk word. A word differing from the source ends the run with result 6 (verify).
- R9: Every run ends with a write of 0x00FF at the device base address. After it, done is high for exactly one cycle and result carries the code (0 = success); result reads 0 while done is low.
- R10: A zero-length request performs only the two base-address writes (0x0050, 0x00FF) and ends with result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken while idle |
| start_addr | input | ADDR_W | First flash word address of the run |
| start_len | input | LEN_W | Run length in bytes |
| start_depth | input | DEPTH_W | Device write-buffer depth in words |
| src_idx | output | LEN_W | Word index into the source buffer |
| src_data | input | 16 | Source word at src_idx, same cycle |
| mem_req | output | 1 | Flash access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Flash word address |
| mem_wdata | output | 16 | Write data or command code |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 3 | Result code, valid with done |

## Verification
A corrupted chunk counter or remaining-length register shows up on the memory port within one chunk. It appears as a wrong count word, as data landing at the wrong flash address, or as an extra or missing chunk. All of these are visible in the recorded write stream and in the flash image at done. A wrong retry counter shows up as an E8 or poll count that differs from MAX_TRIES on the timeout paths. A wrong decode priority shows up as the wrong result code in the single done cycle of the run that injected the status bits.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] CMD_CLR_STATUS = 16'h0050;
    localparam logic [WORD_W-1:0] CMD_ARRAY      = 16'h00FF;
    localparam logic [WORD_W-1:0] CMD_BUF_SETUP  = 16'h00E8;
    localparam logic [WORD_W-1:0] CMD_CONFIRM    = 16'h00D0;

    typedef enum logic [3:0] {
        S_IDLE, S_CLR, S_SETUP_WR, S_SETUP_RD, S_COUNT, S_DATA,
        S_CONFIRM, S_POLL, S_CLR2, S_ARRAY, S_VERIFY, S_FINAL, S_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_TIMEOUT = 3'd1,
        RES_DEVICE  = 3'd2,
        RES_LOWV    = 3'd3,
        RES_PROTECT = 3'd4,
        RES_PROGRAM = 3'd5,
        RES_VERIFY  = 3'd6
    } result_e;
endpackage

// File: rtl/nbp_chunk_calc.sv
module nbp_chunk_calc #(
    parameter int LEN_W   = 12,
    parameter int DEPTH_W = 5
) (
    input  logic [LEN_W-1:0]   rem_bytes,
    input  logic [DEPTH_W-1:0] depth,
    output logic [DEPTH_W-1:0] words,
    output logic [LEN_W-1:0]   next_rem
);
    logic [LEN_W-1:0] half_len;
    logic [LEN_W-1:0] depth_ext;
    logic             full;

    always_comb begin
        half_len  = rem_bytes >> 1;
        depth_ext = LEN_W'(depth);
        full      = (half_len >= depth_ext);
        if (full) begin
            words    = depth;
            next_rem = rem_bytes - (depth_ext << 1);
        end else begin
            // partial chunk rounds an odd byte up and closes the run
            words    = DEPTH_W'(half_len) + DEPTH_W'(rem_bytes[0]);
            next_rem = '0;
        end
    end
endmodule

// File: rtl/nbp_status_decode.sv
module nbp_status_decode
    import nbp_pkg::*;
(
    input  logic [7:0] stat,
    output logic       ready,
    output logic       err,
    output result_e    code
);
    logic unused_stat0;
    assign unused_stat0 = stat[0];

    always_comb begin
        ready = stat[7];
        err   = |(stat[6:1]);
        if (!err)          code = RES_OK;
        else if (!stat[4]) code = RES_DEVICE;
        else if (stat[3])  code = RES_LOWV;
        else if (stat[1])  code = RES_PROTECT;
        else               code = RES_PROGRAM;
    end
endmodule

// File: rtl/nor_bufprog_seq.sv
module nor_bufprog_seq
    import nbp_pkg::*;
#(
    parameter int              ADDR_W    = 24,
    parameter int              LEN_W     = 16,
    parameter int              DEPTH_W   = 6,
    parameter int              MAX_TRIES = 5000000,
    parameter logic [ADDR_W-1:0] BASE_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic [LEN_W-1:0]     start_len,
    input  logic [DEPTH_W-1:0]   start_depth,
    output logic [LEN_W-1:0]     src_idx,
    input  logic [WORD_W-1:0]    src_data,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 mem_ack,
    output logic                 done,
    output logic [2:0]           result
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);

    typedef struct packed {
        seq_state_e          st;
        logic [ADDR_W-1:0]   base;
        logic [ADDR_W-1:0]   caddr;
        logic [LEN_W-1:0]    rem;
        logic [DEPTH_W-1:0]  depth;
        logic [DEPTH_W-1:0]  words;
        logic [DEPTH_W-1:0]  idx;
        logic [LEN_W-1:0]    spos;
        logic [TRY_W-1:0]    tries;
        result_e             res;
    } regs_t;

    regs_t q, d;

    logic [DEPTH_W-1:0] cc_words;
    logic [LEN_W-1:0]   cc_next_rem;
    logic               st_ready, st_err;
    result_e            st_code;
    logic               last_word;
    logic               xfer;

    nbp_chunk_calc #(.LEN_W(LEN_W), .DEPTH_W(DEPTH_W)) u_chunk (
        .rem_bytes (q.rem),
        .depth     (q.depth),
        .words     (cc_words),
        .next_rem  (cc_next_rem)
    );

    nbp_status_decode u_dec (
        .stat  (mem_rdata[7:0]),
        .ready (st_ready),
        .err   (st_err),
        .code  (st_code)
    );

    assign last_word = (q.idx == q.words - DEPTH_W'(1));
    assign xfer      = mem_req && mem_ack;
    assign src_idx   = q.spos + LEN_W'(q.idx);
    assign done      = (q.st == S_DONE);
    assign result    = done ? q.res : RES_OK;

    // memory port is a pure function of the registered state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = q.caddr;
        mem_wdata = '0;
        unique case (q.st)
            S_CLR:      begin mem_addr = q.base; mem_wdata = CMD_CLR_STATUS; end
            S_SETUP_WR: mem_wdata = CMD_BUF_SETUP;
            S_SETUP_RD: mem_we = 1'b0;
            S_COUNT:    mem_wdata = WORD_W'(q.words - DEPTH_W'(1));
            S_DATA:     begin mem_addr = q.caddr + ADDR_W'(q.idx); mem_wdata = src_data; end
            S_CONFIRM:  mem_wdata = CMD_CONFIRM;
            S_POLL:     mem_we = 1'b0;
            S_CLR2:     mem_wdata = CMD_CLR_STATUS;
            S_ARRAY:    mem_wdata = CMD_ARRAY;
            S_VERIFY:   begin mem_we = 1'b0; mem_addr = q.caddr + ADDR_W'(q.idx); end
            S_FINAL:    begin mem_addr = q.base; mem_wdata = CMD_ARRAY; end
            default:    begin mem_req = 1'b0; mem_we = 1'b0; end
        endcase
    end

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: if (start) begin
                d.st    = S_CLR;
                d.base  = start_addr & BASE_MASK;
                d.caddr = start_addr;
                d.rem   = start_len;
                d.depth = (start_depth == '0) ? DEPTH_W'(1) : start_depth;
                d.spos  = '0;
                d.idx   = '0;
                d.res   = RES_OK;
            end
            S_CLR: if (xfer) begin
                if (q.rem == '0) d.st = S_FINAL;
                else begin
                    d.st    = S_SETUP_WR;
                    d.words = cc_words;
                    d.rem   = cc_next_rem;
                    d.tries = '0;
                    d.idx   = '0;
                end
            end
            S_SETUP_WR: if (xfer) d.st = S_SETUP_RD;
            S_SETUP_RD: if (xfer) begin
                if (st_ready) begin
                    d.st    = S_COUNT;
                    d.tries = '0;
                end else if (q.tries == TRY_LAST) begin
                    d.st  = S_FINAL;
                    d.res = RES_TIMEOUT;
                end else begin
                    d.st    = S_SETUP_WR;
                    d.tries = q.tries + TRY_W'(1);
                end
            end
            S_COUNT: if (xfer) begin
                d.st  = S_DATA;
                d.idx = '0;
            end
            S_DATA: if (xfer) begin
                if (last_word) d.st = S_CONFIRM;
                else           d.idx = q.idx + DEPTH_W'(1);
            end
            S_CONFIRM: if (xfer) begin
                d.st    = S_POLL;
                d.tries = '0;
            end
            S_POLL: if (xfer) begin
                if (st_ready) begin
                    if (st_err) begin
                        d.st  = S_FINAL;
                        d.res = st_code;
                    end else d.st = S_CLR2;
                end else if (q.tries == TRY_LAST) begin
                    d.st  = S_FINAL;
                    d.res = RES_TIMEOUT;
                end else d.tries = q.tries + TRY_W'(1);
            end
            S_CLR2:  if (xfer) d.st = S_ARRAY;
            S_ARRAY: if (xfer) begin
                d.st  = S_VERIFY;
                d.idx = '0;
            end
            S_VERIFY: if (xfer) begin
                if (mem_rdata != src_data) begin
                    d.st  = S_FINAL;
                    d.res = RES_VERIFY;
                end else if (last_word) begin
                    d.spos  = q.spos + LEN_W'(q.words);
                    d.caddr = q.caddr + ADDR_W'(q.words);
                    d.idx   = '0;
                    if (q.rem == '0) d.st = S_FINAL;
                    else begin
                        d.st    = S_SETUP_WR;
                        d.words = cc_words;
                        d.rem   = cc_next_rem;
                        d.tries = '0;
                    end
                end else d.idx = q.idx + DEPTH_W'(1);
            end
            S_FINAL: if (xfer) d.st = S_DONE;
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.res   <= RES_OK;
            q.depth <= DEPTH_W'(1);
        end else begin
            q <= d;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))) // R4
        else $error("request changed before acknowledge");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R9
        else $error("done longer than one cycle");

    AST_DONE_AFTER_RESET_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_ack && mem_we && mem_wdata == CMD_ARRAY && mem_addr == q.base)) // R9
        else $error("done without final array write at base");

    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st inside {S_SETUP_WR, S_SETUP_RD, S_COUNT, S_DATA, S_CONFIRM, S_POLL})
            |-> (q.words != '0 && q.words <= q.depth)) // R2
        else $error("chunk size out of range");

    AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        q.tries < TRY_W'(MAX_TRIES)) // R3
        else $error("retry counter past limit");

    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (result == 3'd0)) // R9
        else $error("result nonzero outside done");
endmodule

// File: tb/nor_bufprog_seq_test.sv
module nor_bufprog_seq_test;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int DEPTH_W = 5;
    localparam int MAXT   = 6;
    localparam logic [15:0] BMASK = 16'hFF00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0]  start_len = '0;
    logic [DEPTH_W-1:0] start_depth = '0;
    logic [LEN_W-1:0]  src_idx;
    logic [15:0]       src_data;
    logic mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic done;
    logic [2:0] result;

    always #4 clk = ~clk;

    nor_bufprog_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH_W(DEPTH_W),
                      .MAX_TRIES(MAXT), .BASE_MASK(BMASK)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_len(start_len), .start_depth(start_depth), .src_idx(src_idx),
        .src_data(src_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .done(done), .result(result));

    // source buffer
    logic [15:0] src [256];
    assign src_data = src[src_idx[7:0]];

    // flash stub configuration, written only by the stimulus process
    logic stub_clr = 1'b0;
    int   setup_busy_cfg = 0;
    bit   never_rdy = 0;
    int   prog_busy_cfg = 0;
    logic [7:0] inj = 8'h00;
    bit   corrupt_en = 0;
    int   corrupt_at = 0;

    // flash stub state
    typedef enum int {M_ARRAY, M_STATUS, M_WB_STAT, M_WB_DATA, M_WB_CONF} fmode_e;
    fmode_e fmode;
    logic [15:0] fmem [256];
    logic [15:0] lg_a [512];
    logic [15:0] lg_d [512];
    int   cnt_log [64];
    int   nlog, ncnt, ndata, setup_left, busy_left, left;
    bit   wb_rdy;
    logic ack_r = 1'b0;
    logic [15:0] rd_r = '0;
    assign mem_ack = ack_r;
    assign mem_rdata = rd_r;

    always @(posedge clk) begin
        if (stub_clr) begin
            ack_r <= 1'b0;
            fmode = M_ARRAY;
            nlog = 0; ncnt = 0; ndata = 0; left = 0;
            setup_left = setup_busy_cfg; busy_left = 0; wb_rdy = 0;
            for (int i = 0; i < 256; i++) fmem[i] = 16'hFFFF;
        end else if (mem_req && !ack_r) begin
            ack_r <= 1'b1;
            if (mem_we) begin
                if (nlog < 512) begin lg_a[nlog] = mem_addr; lg_d[nlog] = mem_wdata; end
                nlog++;
                if (fmode == M_WB_DATA) begin
                    fmem[mem_addr[7:0]] = mem_wdata ^ ((corrupt_en && ndata == corrupt_at) ? 16'h0001 : 16'h0000);
                    ndata++;
                    left--;
                    if (left == 0) fmode = M_WB_CONF;
                end else if (fmode == M_WB_STAT && wb_rdy && mem_wdata != 16'h00E8) begin
                    if (ncnt < 64) cnt_log[ncnt] = int'(mem_wdata);
                    ncnt++;
                    left = int'(mem_wdata) + 1;
                    fmode = M_WB_DATA;
                end else if (fmode == M_WB_CONF && mem_wdata == 16'h00D0) begin
                    fmode = M_STATUS;
                    busy_left = prog_busy_cfg;
                end else if (mem_wdata == 16'h00FF) begin
                    fmode = M_ARRAY;
                end else if (mem_wdata == 16'h00E8) begin
                    fmode = M_WB_STAT;
                    if (never_rdy) wb_rdy = 0;
                    else if (setup_left > 0) begin wb_rdy = 0; setup_left--; end
                    else wb_rdy = 1;
                end
            end else begin
                case (fmode)
                    M_ARRAY:   rd_r <= fmem[mem_addr[7:0]];
                    M_WB_STAT: rd_r <= wb_rdy ? 16'h0080 : 16'h0000;
                    M_STATUS: begin
                        if (busy_left > 0) begin busy_left--; rd_r <= 16'h0000; end
                        else rd_r <= 16'h0080 | {8'h00, inj};
                    end
                    default:   rd_r <= 16'h0000;
                endcase
            end
        end else begin
            ack_r <= 1'b0;
        end
    end

    int nchk = 0;
    int nerr = 0;
    int exp_cnt [64];
    int nexp;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // chunk list computed from the sizing rule (R2)
    task automatic build_exp(input int len, input int depth);
        int rem = len;
        nexp = 0;
        while (rem > 0) begin
            int w;
            if (rem / 2 >= depth) begin w = depth; rem -= 2 * depth; end
            else begin w = rem / 2 + rem % 2; rem = 0; end
            exp_cnt[nexp] = w - 1;
            nexp++;
        end
    endtask

    function automatic int count_wr(input int val);
        int n = 0;
        for (int i = 0; i < nlog && i < 512; i++) if (int'(lg_d[i]) == val) n++;
        return n;
    endfunction

    task automatic run(input int addr, input int len, input int depth, output int res);
        int cyc = 0;
        @(negedge clk) stub_clr = 1'b1;
        @(negedge clk) stub_clr = 1'b0;
        start = 1'b1; start_addr = ADDR_W'(addr); start_len = LEN_W'(len); start_depth = DEPTH_W'(depth);
        @(negedge clk) start = 1'b0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        if (!done) begin
            chk(0, "R9 run never finished", 0, 1);
            res = -1;
        end else begin
            res = int'(result);
            @(negedge clk);
            chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
        end
    endtask

    task automatic chk_frame(input int addr, input string req);
        int base = addr & int'(BMASK);
        chk(nlog >= 2 && int'(lg_a[0]) == base && lg_d[0] == 16'h0050, {req, " first write clear at base"}, int'(lg_d[0]), 'h50);
        chk(nlog >= 2 && int'(lg_a[nlog-1]) == base && lg_d[nlog-1] == 16'h00FF, {req, " last write array at base"}, int'(lg_d[nlog-1]), 'hFF);
    endtask

    task automatic chk_image(input int addr, input int len, input string req);
        int bad = 0;
        int words = len / 2 + len % 2;
        for (int i = 0; i < words; i++) if (fmem[(addr + i) & 255] != src[i]) bad++;
        chk(bad == 0, {req, " flash image matches source"}, bad, 0);
    endtask

    task automatic chk_counts(input int len, input int depth, input string req);
        int bad = 0;
        build_exp(len, depth);
        if (ncnt != nexp) bad++;
        else for (int i = 0; i < nexp; i++) if (cnt_log[i] != exp_cnt[i]) bad++;
        chk(bad == 0, {req, " count words per chunk"}, ncnt, nexp);
    endtask

    task automatic cfg_clear;
        setup_busy_cfg = 0; never_rdy = 0; prog_busy_cfg = 0; inj = 8'h00;
        corrupt_en = 0; corrupt_at = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        int res;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) src[i] = 16'($urandom);
        stub_clr = 1'b1;
        repeat (3) @(negedge clk);
        stub_clr = 1'b0;
        chk(done == 1'b0 && mem_req == 1'b0 && result == 3'd0, "R9 reset state quiet", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0, "R9 idle after reset", int'(mem_req), 0);

        // R4 R8 exact write stream for one full chunk
        cfg_clear();
        run('h0110, 8, 4, res);
        chk(res == 0, "R8 single chunk result", res, 0);
        begin
            int ea [11] = '{'h0100,'h0110,'h0110,'h0110,'h0111,'h0112,'h0113,'h0110,'h0110,'h0110,'h0100};
            int ed [11];
            int bad = 0;
            ed = '{'h50,'hE8,3,int'(src[0]),int'(src[1]),int'(src[2]),int'(src[3]),'hD0,'h50,'hFF,'hFF};
            if (nlog != 11) bad++;
            else for (int i = 0; i < 11; i++) if (int'(lg_a[i]) != ea[i] || int'(lg_d[i]) != ed[i]) bad++;
            chk(bad == 0, "R4 R8 write stream order", nlog, 11);
        end
        chk_frame('h0110, "R1");
        chk_image('h0110, 8, "R4");

        // R2 odd length rounds up
        run('h0120, 7, 8, res);
        chk(res == 0, "R2 odd length result", res, 0);
        chk_counts(7, 8, "R2 odd");
        chk_image('h0120, 7, "R2 odd");

        // R2 several chunks with a short tail
        run('h0130, 20, 4, res);
        chk(res == 0, "R2 multi chunk result", res, 0);
        chk_counts(20, 4, "R2 multi");
        chk_image('h0130, 20, "R2 multi");

        // R10 zero length
        run('h0140, 0, 4, res);
        chk(res == 0 && nlog == 2, "R10 zero length", nlog, 2);
        chk_frame('h0140, "R10");

        // R3 buffer busy for three tries
        setup_busy_cfg = 3;
        run('h0150, 8, 4, res);
        chk(res == 0, "R3 retry result", res, 0);
        chk(count_wr('hE8) == 4, "R3 setup writes after busy", count_wr('hE8), 4);
        cfg_clear();

        // R3 buffer never ready
        never_rdy = 1;
        run('h0150, 8, 4, res);
        chk(res == 1, "R3 setup timeout code", res, 1);
        chk(count_wr('hE8) == MAXT, "R3 setup tries", count_wr('hE8), MAXT);
        chk(count_wr('hD0) == 0, "R3 no confirm after timeout", count_wr('hD0), 0);
        chk_frame('h0150, "R9 timeout");
        cfg_clear();

        // R5 completion polling
        prog_busy_cfg = 3;
        run('h0160, 6, 4, res);
        chk(res == 0, "R5 poll then ready", res, 0);
        chk_image('h0160, 6, "R5");
        prog_busy_cfg = 100;
        run('h0160, 6, 4, res);
        chk(res == 1, "R5 poll timeout code", res, 1);
        chk_frame('h0160, "R9 poll timeout");
        cfg_clear();

        // R6 R7 status error decode, multi-chunk run stops after the first
        begin
            logic [7:0] ib [6] = '{8'h10, 8'h18, 8'h12, 8'h1A, 8'h20, 8'h40};
            int         ec [6] = '{5, 3, 4, 3, 2, 2};
            for (int k = 0; k < 6; k++) begin
                inj = ib[k];
                run('h0170, 16, 4, res);
                chk(res == ec[k], "R6 error code", res, ec[k]);
                chk(count_wr('hD0) == 1, "R7 no chunk after error", count_wr('hD0), 1);
                chk(int'(lg_d[nlog-2]) == 'hD0, "R7 no clear after failing poll", int'(lg_d[nlog-2]), 'hD0);
            end
        end
        cfg_clear();

        // R8 readback mismatch in the second chunk
        corrupt_en = 1; corrupt_at = 5;
        run('h0180, 16, 4, res);
        chk(res == 6, "R8 verify code", res, 6);
        chk(count_wr('hD0) == 2, "R8 stop after bad chunk", count_wr('hD0), 2);
        chk_frame('h0180, "R9 verify");
        cfg_clear();

        // random runs
        for (int t = 0; t < 20; t++) begin
            int a = 'h0100 + $urandom_range(0, 100);
            int l = $urandom_range(0, 60);
            int dp = $urandom_range(1, 16);
            for (int i = 0; i < 256; i++) src[i] = 16'($urandom);
            setup_busy_cfg = $urandom_range(0, 3);
            prog_busy_cfg = $urandom_range(0, 4);
            run(a, l, dp, res);
            chk(res == 0, "R2 random result", res, 0);
            chk_counts(l, dp, "R2 random");
            chk_image(a, l, "R4 random");
            chk_frame(a, "R1 random");
        end

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule